// File: doc/BRIEF.md
# Read-Sequence Command Detector

This block sits beside the host port of a non-volatile static memory and watches for a hidden command made of read accesses. Every access is presented to it as a one-cycle event, already synchronized to the block clock, that marks the moment the chip enable went active. The block takes the write-enable level and the address bus at that moment. When the host performs six back-to-back reads from a fixed list of addresses, the block sends one pulse to the store/recall controller. The final address of the six selects the kind of pulse: a store request (copy the array into non-volatile cells) or a recall request (copy the non-volatile cells back into the array).

Matching uses only the low fourteen address bits. Any write, or any read from an address that does not fit the current step, cancels the partial sequence. A cancelling read whose address equals the first pattern counts as a fresh first step. While the controller reports that it is busy, or while the supply is flagged as below its switching level, the detector stays idle and ignores every access. The data the reads return and the timing of the bus are handled elsewhere.

Top module: `cmdseq_detect`

## Requirements
- R1: While `rst_n` is low, and at the first sampling after reset, `store_req` and `recall_req` are 0, and reset discards any partial sequence.
- R2: Six consecutive access events with `we_n`=1 at low-14-bit addresses 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F, 0x0FC0 raise `store_req` for exactly the clock cycle after the sixth event.
- R3: The same five leading reads followed by a sixth read at 0x0C63 raise `recall_req` for exactly the clock cycle after the sixth event.
- R4: Address bits at position 14 and above have no effect on matching. A sequence with bit 14 set on every step still produces its request.
- R5: An access event with `we_n`=0 at any step cancels the sequence, and the remaining steps then produce no request.
- R6: A read event whose address does not fit the current step cancels the sequence, and no request follows from the remaining steps.
- R7: A cancelling read whose address is 0x0E38 is taken as step one, so the next five matching reads complete a command.
- R8: While `busy` or `low_supply` is 1, access events are ignored, any partial sequence is discarded, and no request is raised, including when the sixth event falls in that cycle.
- R9: After a request the detector is back at step one. A repeat of the sixth address alone raises nothing.
- R10: `store_req` and `recall_req` are never high together, and neither stays high for two cycles in a row.
- R11: Only cycles with `ce_fall`=1 are counted as accesses. Changes on `we_n` or `addr` in other cycles leave the sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_fall | input | 1 | One-cycle event: chip enable has just gone active |
| we_n | input | 1 | Write-enable level at the access, 1 means read |
| addr | input | ADDR_W | Host address bus |
| busy | input | 1 | Store/recall controller is running an operation |
| low_supply | input | 1 | Supply is below the switching level |
| store_req | output | 1 | One-cycle request to store the array |
| recall_req | output | 1 | One-cycle request to recall the array |

## Verification
The completing access and the hold condition can fall in the same cycle: the sixth matching read arrives together with `low_supply`, or together with `busy`, high. The bench drives both in the same cycle for both hold sources. It then checks that no request appears in the following cycle and that a later sixth address alone does nothing, which shows that the hold also discarded the five earlier steps. A second coincidence is a cancelling read that is also the first pattern. The bench checks that this read is counted as step one by completing a recall with only five further reads.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

   // width of the compared part of the address
   localparam int PAT_W   = 14;
   // number of leading reads shared by both commands
   localparam int PRE_N   = 5;
   // total number of accesses in one command
   localparam int SEQ_LEN = PRE_N + 1;
   // width of the step counter
   localparam int STEP_W  = $clog2(SEQ_LEN);

   localparam logic [PAT_W-1:0] STORE_PAT  = 14'h0FC0;
   localparam logic [PAT_W-1:0] RECALL_PAT = 14'h0C63;

   // leading pattern for a given step; the order is part of the behaviour
   function automatic logic [PAT_W-1:0] lead_pat(input int idx);
      logic [PAT_W-1:0] p;
      case (idx)
         0:       p = 14'h0E38;
         1:       p = 14'h31C7;
         2:       p = 14'h03E0;
         3:       p = 14'h3C1F;
         default: p = 14'h303F;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/cmdseq_match.sv
module cmdseq_match
   import cmdseq_pkg::*;
(
   input  logic [PAT_W-1:0] key,
   output logic [PRE_N-1:0] lead_hit,
   output logic             store_hit,
   output logic             recall_hit
);

   // one comparator per leading pattern
   for (genvar g = 0; g < PRE_N; g++) begin : g_lead
      assign lead_hit[g] = (key == lead_pat(g));
   end

   assign store_hit  = (key == STORE_PAT);
   assign recall_hit = (key == RECALL_PAT);

endmodule

// File: rtl/cmdseq_step.sv
module cmdseq_step
   import cmdseq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              access,
   input  logic              is_read,
   input  logic              hold,
   input  logic [PRE_N-1:0]  lead_hit,
   input  logic              store_hit,
   input  logic              recall_hit,
   output logic [STEP_W-1:0] step_q,
   output logic              store_q,
   output logic              recall_q
);

   localparam logic [STEP_W-1:0] LAST = STEP_W'(PRE_N);

   logic              cur_hit;
   logic [STEP_W-1:0] step_d;
   logic              store_d;
   logic              recall_d;

   // pick the comparator that belongs to the current step
   always_comb begin
      cur_hit = 1'b0;
      for (int i = 0; i < PRE_N; i++) begin
         if (step_q == STEP_W'(i)) cur_hit = lead_hit[i];
      end
   end

   always_comb begin
      step_d   = step_q;
      store_d  = 1'b0;
      recall_d = 1'b0;
      if (hold) begin
         step_d = '0;
      end else if (access) begin
         if (!is_read) begin
            step_d = '0;
         end else if (cur_hit) begin
            step_d = step_q + 1'b1;
         end else if (step_q == LAST && store_hit) begin
            store_d = 1'b1;
            step_d  = '0;
         end else if (step_q == LAST && recall_hit) begin
            recall_d = 1'b1;
            step_d   = '0;
         end else if (lead_hit[0]) begin
            step_d = STEP_W'(1);
         end else begin
            step_d = '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q   <= '0;
         store_q  <= 1'b0;
         recall_q <= 1'b0;
      end else begin
         step_q   <= step_d;
         store_q  <= store_d;
         recall_q <= recall_d;
      end
   end

endmodule

// File: rtl/cmdseq_detect.sv
module cmdseq_detect
   import cmdseq_pkg::*;
#(
   parameter int ADDR_W = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_fall,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              busy,
   input  logic              low_supply,
   output logic              store_req,
   output logic              recall_req
);

   if (ADDR_W < PAT_W) begin : g_bad_width
      $error("cmdseq_detect: ADDR_W must be at least PAT_W");
   end

   // bits above the compared field play no part
   if (ADDR_W > PAT_W) begin : g_upper
      logic unused_upper;
      assign unused_upper = ^addr[ADDR_W-1:PAT_W];
   end

   logic [PRE_N-1:0]  lead_hit;
   logic              store_hit;
   logic              recall_hit;
   logic [STEP_W-1:0] step_q;

   cmdseq_match u_match (
      .key        (addr[PAT_W-1:0]),
      .lead_hit   (lead_hit),
      .store_hit  (store_hit),
      .recall_hit (recall_hit)
   );

   cmdseq_step u_step (
      .clk        (clk),
      .rst_n      (rst_n),
      .access     (ce_fall),
      .is_read    (we_n),
      .hold       (busy | low_supply),
      .lead_hit   (lead_hit),
      .store_hit  (store_hit),
      .recall_hit (recall_hit),
      .step_q     (step_q),
      .store_q    (store_req),
      .recall_q   (recall_req)
   );

endmodule

// File: rtl/cmdseq_detect_chk.sv
module cmdseq_detect_chk
   import cmdseq_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              ce_fall,
   input logic              we_n,
   input logic              busy,
   input logic              low_supply,
   input logic              store_req,
   input logic              recall_req,
   input logic [STEP_W-1:0] step
);

   // R10: the two requests are exclusive
   p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(store_req && recall_req));

   // R10: each request lasts one cycle
   p_store_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      store_req |=> !store_req);
   p_recall_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      recall_req |=> !recall_req);

   // R11: a request follows an access event
   p_store_event_r11: assert property (@(posedge clk) disable iff (!rst_n)
      store_req |-> $past(ce_fall));
   p_recall_event_r11: assert property (@(posedge clk) disable iff (!rst_n)
      recall_req |-> $past(ce_fall));

   // R5: the completing access is a read
   p_read_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (store_req || recall_req) |-> $past(we_n));

   // R8: no request from a held cycle, and hold empties the sequence
   p_no_req_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (store_req || recall_req) |-> !$past(busy || low_supply));
   p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy || low_supply) |-> (step == '0));

   // R9: back to the start after a request
   p_idle_after_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (store_req || recall_req) |-> (step == '0));

endmodule

bind cmdseq_detect cmdseq_detect_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ce_fall    (ce_fall),
   .we_n       (we_n),
   .busy       (busy),
   .low_supply (low_supply),
   .store_req  (store_req),
   .recall_req (recall_req),
   .step       (step_q)
);

// File: tb/sim_cmdseq_detect.sv
module sim_cmdseq_detect;

   localparam int ADDR_W = 15;
   localparam int NVEC   = 61;
   localparam int VW     = 25;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ce_fall = 1'b0;
   logic              we_n = 1'b1;
   logic [ADDR_W-1:0] addr = '0;
   logic              busy = 1'b0;
   logic              low_supply = 1'b0;
   logic              store_req;
   logic              recall_req;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   cmdseq_detect #(.ADDR_W(ADDR_W)) u0 (
      .clk(clk), .rst_n(rst_n), .ce_fall(ce_fall), .we_n(we_n), .addr(addr),
      .busy(busy), .low_supply(low_supply),
      .store_req(store_req), .recall_req(recall_req)
   );

   // vector fields: req id, ce, we_n, busy, low, addr, expected store, expected recall
   function automatic logic [VW-1:0] v(input int req, input bit ce, input bit wn,
                                       input bit bz, input bit lo,
                                       input logic [14:0] a, input bit es, input bit er);
      return {4'(req), ce, wn, bz, lo, a, es, er};
   endfunction

   localparam logic [14:0] A0 = 15'h0E38, A1 = 15'h31C7, A2 = 15'h03E0,
                           A3 = 15'h3C1F, A4 = 15'h303F, SS = 15'h0FC0, RC = 15'h0C63;
   localparam logic [14:0] HI = 15'h4000;

   localparam logic [VW-1:0] VEC [0:NVEC-1] = '{
      // R2 store
      v(2,1,1,0,0,A0,0,0), v(2,1,1,0,0,A1,0,0), v(2,1,1,0,0,A2,0,0),
      v(2,1,1,0,0,A3,0,0), v(2,1,1,0,0,A4,0,0), v(2,1,1,0,0,SS,1,0),
      // R9 repeat of last address, then quiet cycle
      v(9,1,1,0,0,SS,0,0), v(9,0,1,0,0,15'h0,0,0),
      // R3 recall
      v(3,1,1,0,0,A0,0,0), v(3,1,1,0,0,A1,0,0), v(3,1,1,0,0,A2,0,0),
      v(3,1,1,0,0,A3,0,0), v(3,1,1,0,0,A4,0,0), v(3,1,1,0,0,RC,0,1),
      // R4 bit 14 set everywhere
      v(4,1,1,0,0,A0|HI,0,0), v(4,1,1,0,0,A1|HI,0,0), v(4,1,1,0,0,A2|HI,0,0),
      v(4,1,1,0,0,A3|HI,0,0), v(4,1,1,0,0,A4|HI,0,0), v(4,1,1,0,0,SS|HI,1,0),
      // R5 write at step four
      v(5,1,1,0,0,A0,0,0), v(5,1,1,0,0,A1,0,0), v(5,1,1,0,0,A2,0,0),
      v(5,1,0,0,0,A3,0,0), v(5,1,1,0,0,A4,0,0), v(5,1,1,0,0,SS,0,0),
      // R6 foreign read at step three
      v(6,1,1,0,0,A0,0,0), v(6,1,1,0,0,A1,0,0), v(6,1,1,0,0,15'h1234,0,0),
      v(6,1,1,0,0,A2,0,0), v(6,1,1,0,0,A3,0,0), v(6,1,1,0,0,A4,0,0),
      v(6,1,1,0,0,SS,0,0),
      // R7 first pattern out of place restarts as step one
      v(7,1,1,0,0,A0,0,0), v(7,1,1,0,0,A1,0,0), v(7,1,1,0,0,A2,0,0),
      v(7,1,1,0,0,A0,0,0), v(7,1,1,0,0,A1,0,0), v(7,1,1,0,0,A2,0,0),
      v(7,1,1,0,0,A3,0,0), v(7,1,1,0,0,A4,0,0), v(7,1,1,0,0,RC,0,1),
      // R8 busy during step four
      v(8,1,1,0,0,A0,0,0), v(8,1,1,0,0,A1,0,0), v(8,1,1,0,0,A2,0,0),
      v(8,1,1,1,0,A3,0,0), v(8,1,1,0,0,A4,0,0), v(8,1,1,0,0,SS,0,0),
      // R8 low supply together with the sixth read
      v(8,1,1,0,0,A0,0,0), v(8,1,1,0,0,A1,0,0), v(8,1,1,0,0,A2,0,0),
      v(8,1,1,0,0,A3,0,0), v(8,1,1,0,0,A4,0,0), v(8,1,1,0,1,SS,0,0),
      // R11 bus activity without an access event
      v(11,1,1,0,0,A0,0,0), v(11,1,1,0,0,A1,0,0), v(11,0,0,0,0,15'h7777,0,0),
      v(11,1,1,0,0,A2,0,0), v(11,1,1,0,0,A3,0,0), v(11,1,1,0,0,A4,0,0),
      v(11,1,1,0,0,SS,1,0)
   };

   task automatic check(input int req, input bit es, input bit er);
      n_chk++;
      if (store_req !== es || recall_req !== er) begin
         n_bad++;
         $display("FAIL R%0d: store=%b recall=%b expected store=%b recall=%b",
                  req, store_req, recall_req, es, er);
      end
   endtask

   // called at a falling edge; output is judged after the next rising edge
   task automatic apply(input logic [VW-1:0] vv);
      {ce_fall, we_n, busy, low_supply, addr} = vv[VW-5:2];
      @(posedge clk);
      #5;
      check(int'(vv[VW-1:VW-4]), vv[1], vv[0]);
      @(negedge clk);
      ce_fall = 1'b0;
      we_n = 1'b1;
      busy = 1'b0;
      low_supply = 1'b0;
   endtask

   task automatic quiet(input int req);
      apply(v(req,0,1,0,0,15'h0,0,0));
   endtask

   initial begin
      #3_000_000;
      n_bad++;
      $display("FAIL watchdog: run did not end, expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      // R1 during and right after reset
      repeat (3) @(negedge clk);
      check(1, 1'b0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check(1, 1'b0, 1'b0);

      for (int k = 0; k < NVEC; k++) apply(VEC[k]);

      // R1 reset in mid-sequence discards progress
      apply(v(1,1,1,0,0,A0,0,0));
      apply(v(1,1,1,0,0,A1,0,0));
      apply(v(1,1,1,0,0,A2,0,0));
      apply(v(1,1,1,0,0,A3,0,0));
      apply(v(1,1,1,0,0,A4,0,0));
      rst_n = 1'b0;
      @(negedge clk);
      check(1, 1'b0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      apply(v(1,1,1,0,0,SS,0,0));

      // R8 busy together with the sixth read, then the sixth alone
      apply(v(8,1,1,0,0,A0,0,0));
      apply(v(8,1,1,0,0,A1,0,0));
      apply(v(8,1,1,0,0,A2,0,0));
      apply(v(8,1,1,0,0,A3,0,0));
      apply(v(8,1,1,0,0,A4,0,0));
      apply(v(8,1,1,1,0,RC,0,0));
      apply(v(8,1,1,0,0,RC,0,0));

      // R10 request is gone one cycle later
      apply(v(10,1,1,0,0,A0,0,0));
      apply(v(10,1,1,0,0,A1,0,0));
      apply(v(10,1,1,0,0,A2,0,0));
      apply(v(10,1,1,0,0,A3,0,0));
      apply(v(10,1,1,0,0,A4,0,0));
      apply(v(10,1,1,0,0,RC,0,1));
      quiet(10);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule